// File: doc/BRIEF.md
# DRAM Read Latency Burst Sequencer

This block reproduces the read-side timing of a burst-oriented synchronous DRAM. It is meant for controller test benches and for emulating a memory device behind a memory controller. A mode-register write sets the read latency, which can be any value from 7 to 20 clocks. A READ command carries a column address. Once the programmed latency has passed, the block drives out eight beats. Each beat carries a column index and a data word taken from a small internal pattern array, and the beats always run in ascending order inside one aligned group of eight columns.

The burst length is fixed at eight and cannot be programmed. Every burst begins at offset zero of its group. READs may be issued as often as once every eight clocks. When they are, the bursts follow one another on the output with no idle cycle, and the block can hold up to three commands waiting for their latency to expire. The output is a valid-qualified stream without a ready input, because a DRAM device cannot be stalled and the receiver must accept every beat in the cycle it appears. Illegal commands do not stop the block: each one raises a one-cycle error pulse and the block carries on.

When the latency is lowered while a READ is still pending, two bursts can overlap. A burst that starts later takes over the output from the burst in progress. If two bursts would start on the same edge, the one held in the lower internal slot is used. Hosts are expected not to create such an overlap.

Top module: `rdseq_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, the latency is 7, no burst is pending, and `dq_valid`, `err_mrs`, `err_align` and `err_space` are all 0.
- R2: When `mrs_en` is sampled high and `mrs_addr[6:3]` holds a code c from 0 to 13, the latency becomes 7 + c. All other `mrs_addr` bits are ignored.
- R3: When `mrs_en` is sampled with a code from 14 to 15, `err_mrs` is high for the single cycle after that edge and the latency keeps its old value.
- R4: A READ accepted at edge n, with latency m in effect before that edge, makes `dq_valid` rise at edge n + m.
- R5: A burst is exactly 8 consecutive valid cycles. `dq_col` is `{rd_col[9:3], k}`, where k runs 0, 1, 2 … 7.
- R6: During a valid beat, `dq_data` equals ((dq_col mod 64) × 32'h0101_0101) XOR 32'hC3A5_5A3C.
- R7: A READ with `rd_col[2:0]` non-zero raises `err_align` for the cycle after that edge. The burst is still produced, with the low bits taken as zero.
- R8: A READ sampled fewer than 8 edges after the last accepted READ raises `err_space` for one cycle and produces no burst. It does not restart the spacing count.
- R9: With the latency at 20 and READs issued every 8 clocks, the bursts follow each other with `dq_valid` held high continuously.
- R10: A READ keeps the latency that was in effect when it was accepted. A later mode-register write does not move a pending burst, and an MRS sampled on the same edge as a READ applies only to later READs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mrs_en | input | 1 | Mode-register write strobe |
| mrs_addr | input | 13 | Mode-register value; bits 6:3 hold the latency code |
| rd_en | input | 1 | READ command strobe |
| rd_col | input | 10 | READ column address |
| dq_valid | output | 1 | High while a burst beat is presented |
| dq_col | output | 10 | Column index of the current beat (0 when idle) |
| dq_data | output | 32 | Data word of the current beat (0 when idle) |
| err_mrs | output | 1 | One-cycle pulse: illegal latency code |
| err_align | output | 1 | One-cycle pulse: READ with non-zero low column bits |
| err_space | output | 1 | One-cycle pulse: READ rejected for spacing |

## Verification
The assertions check properties that must hold on every cycle:
- the latency never leaves 7 to 20, and an illegal code leaves it untouched;
- two accepted READs never fall on adjacent edges;
- a slot is never allocated while it is still busy;
- a burst always opens at beat zero, and each following beat advances by one without changing its column group.

Other behaviour can only be shown by the bench's scenarios, which compare every cycle against a queue-based model:
- the exact edge on which a burst appears for each latency;
- the data pattern;
- bursts running back to back at the maximum latency;
- a READ keeping its captured latency when the mode register changes.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  localparam int BURST_LEN    = 8;
  localparam int LAT_MIN      = 7;
  localparam int LAT_MAX      = 20;
  localparam int MR_FIELD_LSB = 3;

  localparam int BEAT_W  = $clog2(BURST_LEN);
  localparam int CODE_W  = $clog2(LAT_MAX - LAT_MIN + 1);
  localparam int CNT_W   = $clog2(LAT_MAX + 1);
  localparam int GAP_W   = $clog2(BURST_LEN + 1);
  localparam int NSLOT   = (LAT_MAX + BURST_LEN - 1) / BURST_LEN;
  localparam int PTR_W   = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int MAX_CODE = LAT_MAX - LAT_MIN;

  localparam logic [31:0] DATA_MULT = 32'h0101_0101;
  localparam logic [31:0] DATA_SALT = 32'hC3A5_5A3C;
endpackage

// File: rtl/rdseq_mode_reg.sv
module rdseq_mode_reg
  import rdseq_pkg::*;
#(
  parameter int MA_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs_en,
  input  logic [MA_W-1:0]  mrs_addr,
  output logic [CNT_W-1:0] lat_q,
  output logic             err_q
);
  logic [CODE_W-1:0] code;
  logic              legal;

  assign code  = mrs_addr[MR_FIELD_LSB +: CODE_W];
  assign legal = (code <= CODE_W'(MAX_CODE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= CNT_W'(LAT_MIN);
      err_q <= 1'b0;
    end else begin
      err_q <= mrs_en && !legal;
      if (mrs_en && legal) begin
        lat_q <= CNT_W'(LAT_MIN) + CNT_W'(code);
      end
    end
  end

  AST_LAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q >= CNT_W'(LAT_MIN)) && (lat_q <= CNT_W'(LAT_MAX))); // R2

  AST_BAD_CODE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_en && (code > CODE_W'(MAX_CODE))) |=> ($stable(lat_q) && err_q)); // R3
endmodule

// File: rtl/rdseq_cmd_gate.sv
module rdseq_cmd_gate
  import rdseq_pkg::*;
#(
  parameter int COL_W = 10,
  localparam int BLK_W = COL_W - BEAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [COL_W-1:0] rd_col,
  output logic             acc,
  output logic [BLK_W-1:0] acc_blk,
  output logic             err_align_q,
  output logic             err_space_q
);
  logic [GAP_W-1:0] gap_q;
  logic             misaligned;

  assign misaligned = |rd_col[BEAT_W-1:0];
  assign acc        = rd_en && (gap_q >= GAP_W'(BURST_LEN));
  assign acc_blk    = rd_col[COL_W-1:BEAT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q       <= GAP_W'(BURST_LEN);
      err_align_q <= 1'b0;
      err_space_q <= 1'b0;
    end else begin
      err_align_q <= rd_en && misaligned;
      err_space_q <= rd_en && !acc;
      if (acc) begin
        gap_q <= GAP_W'(1);
      end else if (gap_q < GAP_W'(BURST_LEN)) begin
        gap_q <= gap_q + GAP_W'(1);
      end
    end
  end

  AST_NO_ADJACENT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !acc); // R8

  AST_ALIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && misaligned) |=> err_align_q); // R7
endmodule

// File: rtl/rdseq_lat_pipe.sv
module rdseq_lat_pipe
  import rdseq_pkg::*;
#(
  parameter int BLK_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [BLK_W-1:0] acc_blk,
  input  logic [CNT_W-1:0] lat,
  output logic             start,
  output logic [BLK_W-1:0] start_blk
);
  logic [NSLOT-1:0] busy_q;
  logic [NSLOT-1:0] expire;
  logic [CNT_W-1:0] cnt_q [NSLOT];
  logic [BLK_W-1:0] blk_q [NSLOT];
  logic [PTR_W-1:0] wptr_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_exp
    assign expire[g] = busy_q[g] && (cnt_q[g] == '0);
  end

  always_comb begin
    start     = 1'b0;
    start_blk = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (expire[i]) begin
        start     = 1'b1;
        start_blk = blk_q[i];
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[g] <= 1'b0;
        cnt_q[g]  <= '0;
        blk_q[g]  <= '0;
      end else if (acc && (wptr_q == PTR_W'(g))) begin
        busy_q[g] <= 1'b1;
        cnt_q[g]  <= lat - CNT_W'(1);
        blk_q[g]  <= acc_blk;
      end else if (expire[g]) begin
        busy_q[g] <= 1'b0;
      end else if (busy_q[g]) begin
        cnt_q[g] <= cnt_q[g] - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
    end else if (acc) begin
      wptr_q <= (wptr_q == PTR_W'(NSLOT - 1)) ? '0 : wptr_q + PTR_W'(1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> !busy_q[wptr_q]); // R9
endmodule

// File: rtl/rdseq_burst_out.sv
module rdseq_burst_out
  import rdseq_pkg::*;
#(
  parameter int COL_W     = 10,
  parameter int DATA_W    = 32,
  parameter int ROM_DEPTH = 64,
  localparam int BLK_W  = COL_W - BEAT_W,
  localparam int ROM_AW = $clog2(ROM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BLK_W-1:0]  start_blk,
  output logic              dq_valid,
  output logic [COL_W-1:0]  dq_col,
  output logic [DATA_W-1:0] dq_data
);
  logic [DATA_W-1:0] rom [ROM_DEPTH];

  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
    assign rom[g] = DATA_W'((32'(g) * DATA_MULT) ^ DATA_SALT);
  end

  logic              act_q, act_n;
  logic [BEAT_W-1:0] beat_q, beat_n;
  logic [BLK_W-1:0]  blk_q, blk_n;
  logic [DATA_W-1:0] data_q;
  logic [COL_W-1:0]  col_n;

  always_comb begin
    act_n  = act_q;
    beat_n = beat_q;
    blk_n  = blk_q;
    if (start) begin
      act_n  = 1'b1;
      beat_n = '0;
      blk_n  = start_blk;
    end else if (act_q) begin
      if (beat_q == BEAT_W'(BURST_LEN - 1)) begin
        act_n = 1'b0;
      end else begin
        beat_n = beat_q + BEAT_W'(1);
      end
    end
  end

  assign col_n = {blk_n, beat_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      beat_q <= '0;
      blk_q  <= '0;
      data_q <= '0;
    end else begin
      act_q  <= act_n;
      beat_q <= beat_n;
      blk_q  <= blk_n;
      data_q <= rom[col_n[ROM_AW-1:0]];
    end
  end

  assign dq_valid = act_q;
  assign dq_col   = act_q ? {blk_q, beat_q} : '0;
  assign dq_data  = act_q ? data_q : '0;

  AST_BURST_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> (beat_q == '0)); // R5

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && (beat_q != BEAT_W'(BURST_LEN - 1)) && !start)
      |=> (act_q && (beat_q == $past(beat_q) + BEAT_W'(1)) && $stable(blk_q))); // R5
endmodule

// File: rtl/rdseq_top.sv
module rdseq_top
  import rdseq_pkg::*;
#(
  parameter int COL_W     = 10,
  parameter int MA_W      = 13,
  parameter int DATA_W    = 32,
  parameter int ROM_DEPTH = 64,
  localparam int BLK_W = COL_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrs_en,
  input  logic [MA_W-1:0]   mrs_addr,
  input  logic              rd_en,
  input  logic [COL_W-1:0]  rd_col,
  output logic              dq_valid,
  output logic [COL_W-1:0]  dq_col,
  output logic [DATA_W-1:0] dq_data,
  output logic              err_mrs,
  output logic              err_align,
  output logic              err_space
);
  logic [CNT_W-1:0] lat;
  logic             acc;
  logic [BLK_W-1:0] acc_blk;
  logic             start;
  logic [BLK_W-1:0] start_blk;

  rdseq_mode_reg #(.MA_W(MA_W)) i_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mrs_en   (mrs_en),
    .mrs_addr (mrs_addr),
    .lat_q    (lat),
    .err_q    (err_mrs)
  );

  rdseq_cmd_gate #(.COL_W(COL_W)) i_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .rd_col      (rd_col),
    .acc         (acc),
    .acc_blk     (acc_blk),
    .err_align_q (err_align),
    .err_space_q (err_space)
  );

  rdseq_lat_pipe #(.BLK_W(BLK_W)) i_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .acc_blk   (acc_blk),
    .lat       (lat),
    .start     (start),
    .start_blk (start_blk)
  );

  rdseq_burst_out #(
    .COL_W     (COL_W),
    .DATA_W    (DATA_W),
    .ROM_DEPTH (ROM_DEPTH)
  ) i_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_blk (start_blk),
    .dq_valid  (dq_valid),
    .dq_col    (dq_col),
    .dq_data   (dq_data)
  );

  AST_START_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (dq_valid && (dq_col[BEAT_W-1:0] == '0) && (dq_col[COL_W-1:BEAT_W] == $past(start_blk)))); // R4
endmodule

// File: tb/test_rdseq_top.sv
module test_rdseq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mrs_en = 1'b0;
  logic [12:0] mrs_addr = '0;
  logic        rd_en = 1'b0;
  logic [9:0]  rd_col = '0;
  logic        dq_valid;
  logic [9:0]  dq_col;
  logic [31:0] dq_data;
  logic        err_mrs, err_align, err_space;

  always #2 clk = ~clk;  // 250 MHz

  rdseq_top i_rdseq_top (
    .clk(clk), .rst_n(rst_n), .mrs_en(mrs_en), .mrs_addr(mrs_addr),
    .rd_en(rd_en), .rd_col(rd_col), .dq_valid(dq_valid), .dq_col(dq_col),
    .dq_data(dq_data), .err_mrs(err_mrs), .err_align(err_align), .err_space(err_space)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R1";
  bit    done = 0;

  // ---------------- behavioural reference model ----------------
  int cyc = 0;
  int m_lat = 7;
  int m_gap = 8;
  int st_q[$];
  int bk_q[$];
  bit m_act = 0;
  int m_beat = 0;
  int m_blk = 0;
  bit m_emrs = 0, m_eal = 0, m_esp = 0;

  function automatic logic [31:0] word_of(int col);
    return ((32'(col % 64)) * 32'h0101_0101) ^ 32'hC3A5_5A3C;  // R6
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_lat = 7; m_gap = 8; st_q.delete(); bk_q.delete();
      m_act = 0; m_beat = 0; m_blk = 0;
      m_emrs = 0; m_eal = 0; m_esp = 0;
    end else begin
      int hit;
      hit = -1;
      foreach (st_q[k]) if (hit < 0 && st_q[k] == cyc) hit = k;
      if (hit >= 0) begin
        m_act = 1; m_beat = 0; m_blk = bk_q[hit];
        st_q.delete(hit); bk_q.delete(hit);
      end else if (m_act) begin
        if (m_beat == 7) m_act = 0; else m_beat++;
      end
      m_eal = 0; m_esp = 0; m_emrs = 0;
      if (rd_en) begin
        m_eal = (rd_col % 8) != 0;
        if (m_gap >= 8) begin
          st_q.push_back(cyc + m_lat);
          bk_q.push_back(int'(rd_col) / 8);
          m_gap = 1;
        end else begin
          m_esp = 1;
          m_gap++;
        end
      end else if (m_gap < 8) m_gap++;
      if (mrs_en) begin
        int c;
        c = int'(mrs_addr[6:3]);
        if (c > 13) m_emrs = 1; else m_lat = 7 + c;
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h (t=%0t)", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("dq_valid", 32'(dq_valid), 32'(m_act));
      chk("err_mrs", 32'(err_mrs), 32'(m_emrs));
      chk("err_align", 32'(err_align), 32'(m_eal));
      chk("err_space", 32'(err_space), 32'(m_esp));
      if (m_act) begin
        chk("dq_col", 32'(dq_col), 32'(m_blk * 8 + m_beat));
        chk("dq_data", dq_data, word_of(m_blk * 8 + m_beat));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [9:0] col);
    @(negedge clk); rd_en = 1; rd_col = col;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic mrs(logic [12:0] a);
    @(negedge clk); mrs_en = 1; mrs_addr = a;
    @(negedge clk); mrs_en = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    // R1: reset state
    phase = "R1";
    idle(3);
    chk("R1 dq_valid in reset", 32'(dq_valid), 32'd0);
    rst_n = 1;
    idle(2);
    chk("R1 dq_valid after reset", 32'(dq_valid), 32'd0);

    // R4: default latency 7
    phase = "R4";
    rd(10'h040);
    idle(20);

    // R2: code 5 -> latency 12, other address bits set
    phase = "R2";
    mrs(13'h1F87 | (13'd5 << 3));
    rd(10'h1A8);
    idle(25);

    // R3: illegal code keeps latency 12
    phase = "R3";
    mrs(13'd15 << 3);
    mrs(13'd14 << 3);
    rd(10'h2C0);
    idle(25);

    // R7: misaligned read
    phase = "R7";
    rd(10'h0B5);
    idle(25);

    // R8: too-early read ignored, counter not restarted
    phase = "R8";
    rd(10'h100);
    idle(1);
    rd(10'h108);
    idle(3);
    rd(10'h110);
    idle(30);

    // R9: latency 20, reads every 8 clocks
    phase = "R9";
    mrs(13'd13 << 3);
    rd(10'h000);
    for (int k = 1; k < 6; k++) begin
      idle(6);
      rd(10'(k * 72 + 8));
    end
    idle(40);

    // R10: pending read keeps its latency; same-edge MRS uses old value
    phase = "R10";
    rd(10'h3F8);
    idle(1);
    mrs(13'd0 << 3);
    idle(30);
    @(negedge clk); rd_en = 1; rd_col = 10'h0C8; mrs_en = 1; mrs_addr = 13'd9 << 3;
    @(negedge clk); rd_en = 0; mrs_en = 0;
    idle(25);
    rd(10'h3C0);
    idle(30);

    // R5, R6: top column group and pattern wrap
    phase = "R5";
    rd(10'h3F8);
    idle(30);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end
endmodule